// File: doc/BRIEF.md
# Static Memory Strobe Timer

This block times one access at a time to an external asynchronous static memory. A requester presents a byte address, a write flag, byte enables and a device-width select, then pulses a request. The block registers a device address and asserts the output-enable strobe (reads) or the write-enable strobe (writes), together with the byte-lane selects. It holds them for a programmed interval, drops them, and one cycle later returns a single-cycle acknowledge.

The interval comes from one of two timing sources. Normal timing holds the strobes for a short per-cycle count. Extended timing stretches the strobes to whole multiples of sixteen bus clocks, using a 4-bit prescaler in front of a 10-bit down-counter. One extended value serves reads and writes alike, so it must be set to cover the slower of the device's two cycle times. For 16-bit devices, a mapping control selects whether the byte address is shifted down by one bit before it reaches the 21-bit device address bus.

Top module: `static_strobe_timer`

## Requirements
- R1: While reset is high and after it, until the first accepted request, `mem_oe`, `mem_we`, `ack` and all bits of `mem_bls` are 0 and `mem_addr` is 0. All strobes are active-high.
- R2: With `ext_wait_en`=1 at acceptance, the active strobe stays high for exactly (`ext_wait_cnt`+1)×16 clock cycles. This covers the full range 0 to 1023.
- R3: With `ext_wait_en`=0 at acceptance, the active strobe stays high for exactly `norm_wait`+1 clock cycles.
- R4: A read (`req_write`=0) raises only `mem_oe` and a write raises only `mem_we`. The two are never high together, and the same timing setting governs both.
- R5: `mem_bls` bit i drives byte lane i. For a write it equals `req_be`; for a read all bits are 1. It is high exactly while the access strobe is high.
- R6: `ack` is high for exactly one cycle, one cycle after the strobe falls. A request raised while a transaction is in progress, up to and including the `ack` cycle, is ignored and starts no access.
- R7: `mem_addr`, `mem_bls` and the strobe type stay constant for the whole strobe interval. Changes to `ext_wait_en`, `ext_wait_cnt`, `norm_wait` or `addr_nomap` after acceptance do not change that transaction.
- R8: For an 8-bit device (`req_wide`=0), `mem_addr` = `req_addr[20:0]`, whatever the value of `addr_nomap`.
- R9: For a 16-bit device (`req_wide`=1) with `addr_nomap`=0, `mem_addr` = `req_addr[21:1]`.
- R10: For a 16-bit device with `addr_nomap`=1, `mem_addr` = `req_addr[20:0]`, unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request pulse, taken only while idle |
| req_addr | input | 24 | Internal byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables for writes |
| req_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| ext_wait_en | input | 1 | Selects extended timing for the bank |
| ext_wait_cnt | input | 10 | Extended count N, length (N+1)×16 |
| norm_wait | input | 5 | Normal wait W, length W+1 |
| addr_nomap | input | 1 | 1 = no shift for 16-bit devices |
| ack | output | 1 | One-cycle completion pulse |
| mem_addr | output | 21 | Registered device address |
| mem_oe | output | 1 | Output-enable strobe, active-high |
| mem_we | output | 1 | Write-enable strobe, active-high |
| mem_bls | output | 2 | Byte-lane selects, active-high |

## Verification
On every cycle the embedded assertions check the cycle-level rules: the two strobes are mutually exclusive, a read drives every lane, the lanes are active only under a strobe, the address is frozen while a strobe is high, the acknowledge is a single pulse that comes after a strobe-free cycle, and the counter expires only once per transaction. Only the bench's scenarios can show the exact strobe lengths for both timing sources (including the counts 0 and 1023), the three address mappings, the byte-lane values for writes, the immunity to configuration changes made mid-transaction, and that a request raised while busy starts no access.

// File: rtl/smt_pkg.sv
package smt_pkg;

    localparam int IN_ADDR_W  = 24;
    localparam int EXT_ADDR_W = 21;
    localparam int EXW_W      = 10;
    localparam int NWAIT_W    = 5;
    localparam int PRE_W      = 4;
    localparam int LANES      = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2,
        ST_ACK    = 2'd3
    } smt_state_e;

    typedef struct packed {
        logic             oe;
        logic             we;
        logic [LANES-1:0] bls;
    } smt_strobe_t;

    function automatic logic [LANES-1:0] lane_pick(input logic is_write,
                                                    input logic [LANES-1:0] be);
        return is_write ? be : {LANES{1'b1}};
    endfunction

endpackage

// File: rtl/smt_addr_map.sv
module smt_addr_map #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 21
) (
    input  logic [IN_W-1:0]  byte_addr,
    input  logic             wide,
    input  logic             nomap,
    output logic [OUT_W-1:0] dev_addr
);
    localparam int SHIFT_HI = OUT_W;

    logic [OUT_W-1:0] plain_addr;
    logic [OUT_W-1:0] halved_addr;

    generate
        if (IN_W > OUT_W) begin : g_wide_in
            assign plain_addr  = byte_addr[OUT_W-1:0];
            assign halved_addr = byte_addr[SHIFT_HI:1];
        end else begin : g_narrow_in
            logic [OUT_W:0] ext_addr;
            assign ext_addr    = {{(OUT_W+1-IN_W){1'b0}}, byte_addr};
            assign plain_addr  = ext_addr[OUT_W-1:0];
            assign halved_addr = ext_addr[SHIFT_HI:1];
        end
    endgenerate

    always_comb begin
        if (wide && !nomap) dev_addr = halved_addr;
        else                dev_addr = plain_addr;
    end
endmodule

// File: rtl/smt_wait_counter.sv
module smt_wait_counter #(
    parameter int CNT_W = 10,
    parameter int NW_W  = 5,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic             ext_mode,
    input  logic [CNT_W-1:0] ext_cnt,
    input  logic [NW_W-1:0]  norm_cnt,
    output logic             expire
);
    localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] main_q;
    logic             ext_q;
    logic             at_zero;

    assign at_zero = (pre_q == '0) && (main_q == '0);
    assign expire  = run && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            main_q <= '0;
            ext_q  <= 1'b0;
        end else if (load) begin
            ext_q  <= ext_mode;
            pre_q  <= ext_mode ? PRE_TOP : '0;
            main_q <= ext_mode ? ext_cnt : CNT_W'(norm_cnt);
        end else if (run && !at_zero) begin
            if (pre_q == '0) begin
                pre_q  <= ext_q ? PRE_TOP : '0;
                main_q <= main_q - 1'b1;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);                                           // R2
    AST_NORMAL_NO_PRESCALE: assert property (@(posedge clk) disable iff (rst)
        (run && !ext_q) |-> (pre_q == '0));                             // R3
endmodule

// File: rtl/smt_ctrl.sv
module smt_ctrl
    import smt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic expire,
    output logic accept,
    output logic running,
    output logic ack
);
    smt_state_e state_q, state_d;

    assign accept  = (state_q == ST_IDLE) && req;
    assign running = (state_q == ST_STROBE);
    assign ack     = (state_q == ST_ACK);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req)    state_d = ST_STROBE;
            ST_STROBE: if (expire) state_d = ST_GAP;
            ST_GAP:                state_d = ST_ACK;
            ST_ACK:                state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);                                                  // R6
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (running || ack) |-> !accept);                                  // R6
endmodule

// File: rtl/static_strobe_timer.sv
module static_strobe_timer
    import smt_pkg::*;
#(
    parameter int IN_W   = smt_pkg::IN_ADDR_W,
    parameter int OUT_W  = smt_pkg::EXT_ADDR_W,
    parameter int EXW    = smt_pkg::EXW_W,
    parameter int NWW    = smt_pkg::NWAIT_W,
    parameter int PREW   = smt_pkg::PRE_W,
    parameter int NLANES = smt_pkg::LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [IN_W-1:0]   req_addr,
    input  logic              req_write,
    input  logic [NLANES-1:0] req_be,
    input  logic              req_wide,
    input  logic              ext_wait_en,
    input  logic [EXW-1:0]    ext_wait_cnt,
    input  logic [NWW-1:0]    norm_wait,
    input  logic              addr_nomap,
    output logic              ack,
    output logic [OUT_W-1:0]  mem_addr,
    output logic              mem_oe,
    output logic              mem_we,
    output logic [NLANES-1:0] mem_bls
);
    logic             accept;
    logic             running;
    logic             expire;
    logic [OUT_W-1:0] dev_addr;
    logic [OUT_W-1:0] addr_q;
    logic             oe_q, we_q;
    logic [NLANES-1:0] bls_q;
    logic [NLANES-1:0] lane_d;

    smt_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .expire  (expire),
        .accept  (accept),
        .running (running),
        .ack     (ack)
    );

    smt_wait_counter #(
        .CNT_W (EXW),
        .NW_W  (NWW),
        .PRE_W (PREW)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .run      (running),
        .ext_mode (ext_wait_en),
        .ext_cnt  (ext_wait_cnt),
        .norm_cnt (norm_wait),
        .expire   (expire)
    );

    smt_addr_map #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W)
    ) u_map (
        .byte_addr (req_addr),
        .wide      (req_wide),
        .nomap     (addr_nomap),
        .dev_addr  (dev_addr)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NLANES; gi++) begin : g_lane
            assign lane_d[gi] = req_write ? req_be[gi] : 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            oe_q   <= 1'b0;
            we_q   <= 1'b0;
            bls_q  <= '0;
        end else if (accept) begin
            addr_q <= dev_addr;
            oe_q   <= !req_write;
            we_q   <= req_write;
            bls_q  <= lane_d;
        end else if (expire) begin
            oe_q  <= 1'b0;
            we_q  <= 1'b0;
            bls_q <= '0;
        end
    end

    assign mem_addr = addr_q;
    assign mem_oe   = oe_q;
    assign mem_we   = we_q;
    assign mem_bls  = bls_q;

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_oe && mem_we));                                           // R4
    AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        mem_oe |-> (&mem_bls));                                         // R5
    AST_LANES_UNDER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (mem_bls != '0) |-> (mem_oe || mem_we));                        // R5
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((mem_oe || mem_we) && $past(mem_oe || mem_we)) |-> $stable(mem_addr)); // R7
    AST_ACK_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        ack |-> (!(mem_oe || mem_we) && $past(!(mem_oe || mem_we))));   // R6
endmodule

// File: tb/tb_static_strobe_timer.sv
module tb_static_strobe_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_be = '0;
    logic        req_wide = 1'b0;
    logic        ext_wait_en = 1'b0;
    logic [9:0]  ext_wait_cnt = '0;
    logic [4:0]  norm_wait = '0;
    logic        addr_nomap = 1'b0;
    logic        ack;
    logic [20:0] mem_addr;
    logic        mem_oe, mem_we;
    logic [1:0]  mem_bls;

    always #5 clk = ~clk;

    static_strobe_timer dut (
        .clk(clk), .rst(rst), .req(req), .req_addr(req_addr),
        .req_write(req_write), .req_be(req_be), .req_wide(req_wide),
        .ext_wait_en(ext_wait_en), .ext_wait_cnt(ext_wait_cnt),
        .norm_wait(norm_wait), .addr_nomap(addr_nomap), .ack(ack),
        .mem_addr(mem_addr), .mem_oe(mem_oe), .mem_we(mem_we), .mem_bls(mem_bls)
    );

    typedef struct {
        logic [20:0] addr;
        logic        write;
        logic [1:0]  bls;
        int          len;
        string       len_tag;
        string       addr_tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   done_cnt = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: pushes the expected item, pulses the request, optionally
    // disturbs configuration or re-requests mid-transaction.
    task automatic drive(input logic [23:0] a, input logic wr, input logic [1:0] be,
                         input logic wide, input logic ext, input int ecnt,
                         input int nw, input logic nomap,
                         input bit disturb, input bit poke);
        exp_t e;
        int target;
        e.write = wr;
        e.bls   = wr ? be : 2'b11;
        e.len   = ext ? (ecnt + 1) * 16 : nw + 1;
        e.len_tag = ext ? "R2" : "R3";
        if (!wide) begin
            e.addr = a[20:0]; e.addr_tag = "R8";
        end else if (!nomap) begin
            e.addr = a[21:1]; e.addr_tag = "R9";
        end else begin
            e.addr = a[20:0]; e.addr_tag = "R10";
        end
        exp_q.push_back(e);
        target = done_cnt + 1;
        @(negedge clk);
        req = 1'b1; req_addr = a; req_write = wr; req_be = be; req_wide = wide;
        ext_wait_en = ext; ext_wait_cnt = ecnt[9:0]; norm_wait = nw[4:0];
        addr_nomap = nomap;
        @(negedge clk);
        req = 1'b0;
        if (disturb || poke) begin
            @(negedge clk);
            @(negedge clk);
            if (disturb) begin   // R7: late configuration changes
                ext_wait_en = ~ext; ext_wait_cnt = 10'd5; norm_wait = 5'd2;
                addr_nomap = ~nomap;
            end
            if (poke) begin      // R6: request while busy is ignored
                req = 1'b1; req_addr = ~a; req_write = ~wr;
                @(negedge clk);
                req = 1'b0;
            end
        end
        wait (done_cnt == target);
    endtask

    // Monitor: pops expectations as strobes appear and compares.
    initial begin
        exp_t e;
        logic [20:0] a0;
        logic [1:0]  b0;
        logic        oe0;
        int len;
        bit stable;
        forever begin
            @(negedge clk);
            if (!rst && (mem_oe || mem_we)) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected access", 1, 0);
                    while (mem_oe || mem_we) @(negedge clk);
                end else begin
                    e = exp_q.pop_front();
                    chk(mem_we == e.write && mem_oe == !e.write, "R4", "strobe type",
                        {mem_oe, mem_we}, {!e.write, e.write});
                    chk(mem_addr == e.addr, e.addr_tag, "device address", mem_addr, e.addr);
                    chk(mem_bls == e.bls, "R5", "byte lanes", mem_bls, e.bls);
                    a0 = mem_addr; b0 = mem_bls; oe0 = mem_oe;
                    len = 0; stable = 1;
                    while (mem_oe || mem_we) begin
                        len++;
                        if (mem_addr != a0 || mem_bls != b0 || mem_oe != oe0) stable = 0;
                        @(negedge clk);
                    end
                    chk(len == e.len, e.len_tag, "strobe length", len, e.len);
                    chk(stable, "R7", "outputs held", stable, 1);
                    chk(mem_bls == 2'b00, "R5", "lanes after strobe", mem_bls, 0);
                    chk(ack == 1'b0, "R6", "ack in gap cycle", ack, 0);
                    @(negedge clk);
                    chk(ack == 1'b1, "R6", "ack cycle", ack, 1);
                    @(negedge clk);
                    chk(ack == 1'b0, "R6", "ack single pulse", ack, 0);
                    done_cnt++;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R6", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_oe == 0 && mem_we == 0 && ack == 0, "R1", "strobes in reset",
            {mem_oe, mem_we, ack}, 0);
        chk(mem_bls == 0 && mem_addr == 0, "R1", "lanes/address in reset", mem_addr, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_oe == 0 && mem_we == 0 && ack == 0 && mem_bls == 0 && mem_addr == 0,
            "R1", "idle after reset", {mem_oe, mem_we, mem_bls}, 0);

        // R3: normal timing, reads and writes, lengths 1, 8, 32
        drive(24'h012345, 1'b0, 2'b00, 1'b0, 1'b0, 0,  0,  1'b0, 0, 0);
        drive(24'h0ABCDE, 1'b1, 2'b01, 1'b0, 1'b0, 0,  7,  1'b1, 0, 0);
        drive(24'h3FFFFF, 1'b1, 2'b10, 1'b1, 1'b0, 0,  31, 1'b0, 0, 0);
        // R2: extended timing, counts 0, 2 and maximum
        drive(24'h155555, 1'b0, 2'b11, 1'b1, 1'b1, 0,  9,  1'b1, 0, 0);
        drive(24'h2AAAAA, 1'b1, 2'b11, 1'b1, 1'b1, 2,  0,  1'b0, 0, 0);
        drive(24'h000001, 1'b1, 2'b01, 1'b0, 1'b1, 1023, 3, 1'b0, 0, 0);
        // R8/R9/R10: address mappings on an odd address
        drive(24'hF00003, 1'b0, 2'b00, 1'b0, 1'b0, 0,  2,  1'b1, 0, 0);
        drive(24'hF00003, 1'b0, 2'b00, 1'b1, 1'b0, 0,  2,  1'b0, 0, 0);
        drive(24'hF00003, 1'b0, 2'b00, 1'b1, 1'b0, 0,  2,  1'b1, 0, 0);
        // R7: configuration disturbed mid-transaction, both timing sources
        drive(24'h123456, 1'b1, 2'b10, 1'b1, 1'b1, 1,  4,  1'b0, 1, 0);
        drive(24'h654321, 1'b0, 2'b00, 1'b1, 1'b0, 0,  20, 1'b1, 1, 0);
        // R6: request while busy is ignored
        drive(24'h0F0F0F, 1'b0, 2'b00, 1'b0, 1'b0, 0,  10, 1'b0, 0, 1);
        drive(24'h111111, 1'b1, 2'b11, 1'b1, 1'b1, 0,  0,  1'b1, 0, 1);

        // R6: no stray access afterwards, queue drained
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
        chk(mem_oe == 0 && mem_we == 0 && ack == 0, "R6", "idle at end",
            {mem_oe, mem_we, ack}, 0);
        report();
    end
endmodule